// File: doc/BRIEF.md
# Debug Test Port with External Register Steering

This block is a boundary-scan test access port controller. It runs the usual sixteen-state test-port sequence on TCK and TMS. Through instruction scans it loads an 8-bit command. The low seven bits of the command name a target register and the top bit says whether the access is a read or a write.

The select field is decoded into one-hot strobes. These strobes steer data-register scans to registers that live outside the core: twelve general-purpose registers, a trace register, a scan-chain register and a debug-enable register. The outside logic sees plain Capture-DR and Shift-DR indications. It also sees an update strobe that fires only for write commands. While a data scan is in progress, the chosen external register returns its bits on one shared serial input, and that input is forwarded to TDO. Any command that names no external register scans through an internal one-bit bypass stage.

Top module: `tap_ext_sel`

## Requirements
- R1: `captureDr` is high exactly while the controller is in Capture-DR.
- R2: `shiftDr` is high exactly while the controller is in Shift-DR.
- R3: `updateWr` is high only in Update-DR and only when command bit 7 (read/write) is 0. It is low in every other state and for read commands (bit 7 = 1).
- R4: A command select field (bits 6:0) of 0x70+n, with n from 0 to 11, raises `gpSel[n]` alone.
- R5: Select 0x7C raises `traceSel`, 0x7D raises `scanSel` and 0x7E raises `dbgEnSel`, each alone.
- R6: Any other select value raises no select output. Data scans then pass through a one-bit bypass stage that loads 0 in Capture-DR.
- R7: While any select output is high, TDO in Shift-DR carries `extData`, sampled on the falling edge of TCK.
- R8: TDO changes only on falling TCK edges and is 0 outside Shift-IR and Shift-DR. In Capture-IR the instruction shifter loads 0x01, and Shift-IR emits it least significant bit first.
- R9: The command is shifted in least significant bit first and takes effect when the controller leaves Update-IR. Its reset value is 0xFF.
- R10: TRST_N low, or five TCK rising edges with TMS high, returns the controller to Test-Logic-Reset and the command to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| trstN | input | 1 | Asynchronous test reset, active low |
| extData | input | 1 | Serial data from the selected external register |
| tdo | output | 1 | Test data out, updated on falling TCK |
| captureDr | output | 1 | Controller is in Capture-DR |
| shiftDr | output | 1 | Controller is in Shift-DR |
| updateWr | output | 1 | Update-DR of a write command |
| gpSel | output | 12 | General-purpose register selects |
| traceSel | output | 1 | Trace register select |
| scanSel | output | 1 | Scan-chain register select |
| dbgEnSel | output | 1 | Debug-enable register select |

## Verification
The decoder is tried with every in-range select code, from 0x70 through 0x7E. It is also tried with the bypass reset code and with codes just below the range, at zero and at a mid value. This shows that exactly one strobe maps to each code and that none leaks at the range edges.

Each code is followed by a data scan. In that scan `extData` and TDI are driven with opposite bit patterns, so TDO shows whether the external path or the bypass stage was chosen.

A read command and a write command to the same register tell apart the write qualification of the update strobe. Reset by TMS and reset by TRST_N both check that the command falls back to bypass.

// File: rtl/tap_ext_pkg.sv
package tap_ext_pkg;
  parameter int SEL_W = 7;
  parameter int IR_W = SEL_W + 1;
  parameter int GP_COUNT = 12;
  parameter logic [SEL_W-1:0] GP_BASE = 7'h70;
  parameter logic [SEL_W-1:0] TRACE_CODE = 7'h7C;
  parameter logic [SEL_W-1:0] SCAN_CODE = 7'h7D;
  parameter logic [SEL_W-1:0] DBGEN_CODE = 7'h7E;
  localparam logic [IR_W-1:0] CMD_RESET = '1;
  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);

  typedef enum logic [3:0] {
    TLR, IDLE, SEL_DR, CAP_DR, SHIFT_DR, EXIT1_DR, PAUSE_DR, EXIT2_DR, UPD_DR,
    SEL_IR, CAP_IR, SHIFT_IR, EXIT1_IR, PAUSE_IR, EXIT2_IR, UPD_IR
  } tapState_e;

  typedef struct packed {
    logic tlr;
    logic capIr;
    logic shiftIr;
    logic updIr;
    logic capDr;
    logic shiftDr;
    logic updDr;
  } tapStrobe_t;
endpackage

// File: rtl/tap_ext_ctrl.sv
module tap_ext_ctrl
  import tap_ext_pkg::*;
(
  input  logic       tck,
  input  logic       tms,
  input  logic       trstN,
  output tapStrobe_t strb
);
  tapState_e state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      TLR:      nextState = tms ? TLR : IDLE;
      IDLE:     nextState = tms ? SEL_DR : IDLE;
      SEL_DR:   nextState = tms ? SEL_IR : CAP_DR;
      CAP_DR:   nextState = tms ? EXIT1_DR : SHIFT_DR;
      SHIFT_DR: nextState = tms ? EXIT1_DR : SHIFT_DR;
      EXIT1_DR: nextState = tms ? UPD_DR : PAUSE_DR;
      PAUSE_DR: nextState = tms ? EXIT2_DR : PAUSE_DR;
      EXIT2_DR: nextState = tms ? UPD_DR : SHIFT_DR;
      UPD_DR:   nextState = tms ? SEL_DR : IDLE;
      SEL_IR:   nextState = tms ? TLR : CAP_IR;
      CAP_IR:   nextState = tms ? EXIT1_IR : SHIFT_IR;
      SHIFT_IR: nextState = tms ? EXIT1_IR : SHIFT_IR;
      EXIT1_IR: nextState = tms ? UPD_IR : PAUSE_IR;
      PAUSE_IR: nextState = tms ? EXIT2_IR : PAUSE_IR;
      EXIT2_IR: nextState = tms ? UPD_IR : SHIFT_IR;
      UPD_IR:   nextState = tms ? SEL_DR : IDLE;
      default:  nextState = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= TLR;
    else        state <= nextState;
  end

  always_comb begin
    strb.tlr     = (state == TLR);
    strb.capIr   = (state == CAP_IR);
    strb.shiftIr = (state == SHIFT_IR);
    strb.updIr   = (state == UPD_IR);
    strb.capDr   = (state == CAP_DR);
    strb.shiftDr = (state == SHIFT_DR);
    strb.updDr   = (state == UPD_DR);
  end

  // Checker-only run length of TMS-high edges
  logic [2:0] tmsRun;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)               tmsRun <= '0;
    else if (!tms)            tmsRun <= '0;
    else if (tmsRun != 3'd5)  tmsRun <= tmsRun + 3'd1;
  end

  AST_CAPTURE_ONE_CYCLE: assert property (@(posedge tck) disable iff (!trstN)
    strb.capDr |=> (strb.shiftDr || state == EXIT1_DR)); // R1
  AST_SHIFT_HOLDS: assert property (@(posedge tck) disable iff (!trstN)
    (strb.shiftDr && !tms) |=> strb.shiftDr); // R2
  AST_FIVE_TMS_RESET: assert property (@(posedge tck) disable iff (!trstN)
    (tmsRun == 3'd5) |-> strb.tlr); // R10
endmodule

// File: rtl/tap_ext_dp.sv
module tap_ext_dp
  import tap_ext_pkg::*;
(
  input  logic                tck,
  input  logic                tdi,
  input  logic                trstN,
  input  logic                extData,
  input  tapStrobe_t          strb,
  output logic                tdo,
  output logic                updateWr,
  output logic [GP_COUNT-1:0] gpSel,
  output logic                traceSel,
  output logic                scanSel,
  output logic                dbgEnSel
);
  logic [IR_W-1:0]  irShift;
  logic [IR_W-1:0]  cmd;
  logic             bypassBit;
  logic             extSel;
  logic [SEL_W-1:0] selCode;
  logic             cmdRead;

  assign selCode = cmd[SEL_W-1:0];
  assign cmdRead = cmd[IR_W-1];

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift   <= IR_CAPTURE;
      cmd       <= CMD_RESET;
      bypassBit <= 1'b0;
    end else begin
      if (strb.tlr)        cmd <= CMD_RESET;
      else if (strb.updIr) cmd <= irShift;
      if (strb.capIr)        irShift <= IR_CAPTURE;
      else if (strb.shiftIr) irShift <= {tdi, irShift[IR_W-1:1]};
      if (strb.capDr)        bypassBit <= 1'b0;
      else if (strb.shiftDr) bypassBit <= tdi;
    end
  end

  for (genvar g = 0; g < GP_COUNT; g++) begin : gGpDecode
    assign gpSel[g] = (selCode == SEL_W'(GP_BASE + SEL_W'(g)));
  end
  assign traceSel = (selCode == TRACE_CODE);
  assign scanSel  = (selCode == SCAN_CODE);
  assign dbgEnSel = (selCode == DBGEN_CODE);
  assign extSel   = (|gpSel) | traceSel | scanSel | dbgEnSel;

  assign updateWr = strb.updDr & ~cmdRead;

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)            tdo <= 1'b0;
    else if (strb.shiftIr) tdo <= irShift[0];
    else if (strb.shiftDr) tdo <= extSel ? extData : bypassBit;
    else                   tdo <= 1'b0;
  end

  AST_SEL_ONEHOT: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({gpSel, traceSel, scanSel, dbgEnSel})); // R4
  AST_CMD_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (!trstN)
    (!strb.updIr && !strb.tlr) |=> $stable(cmd)); // R9
  AST_TDO_QUIET: assert property (@(negedge tck) disable iff (!trstN)
    (!strb.shiftIr && !strb.shiftDr) |=> (tdo == 1'b0)); // R8
endmodule

// File: rtl/tap_ext_sel.sv
module tap_ext_sel
  import tap_ext_pkg::*;
(
  input  logic                tck,
  input  logic                tms,
  input  logic                tdi,
  input  logic                trstN,
  input  logic                extData,
  output logic                tdo,
  output logic                captureDr,
  output logic                shiftDr,
  output logic                updateWr,
  output logic [GP_COUNT-1:0] gpSel,
  output logic                traceSel,
  output logic                scanSel,
  output logic                dbgEnSel
);
  tapStrobe_t strb;

  tap_ext_ctrl i_ctrl (
    .tck   (tck),
    .tms   (tms),
    .trstN (trstN),
    .strb  (strb)
  );

  tap_ext_dp i_dp (
    .tck      (tck),
    .tdi      (tdi),
    .trstN    (trstN),
    .extData  (extData),
    .strb     (strb),
    .tdo      (tdo),
    .updateWr (updateWr),
    .gpSel    (gpSel),
    .traceSel (traceSel),
    .scanSel  (scanSel),
    .dbgEnSel (dbgEnSel)
  );

  assign captureDr = strb.capDr;
  assign shiftDr   = strb.shiftDr;
endmodule

// File: tb/test_tap_ext_sel.sv
`timescale 1ns/100ps
module test_tap_ext_sel;
  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trstN = 1'b0, extData = 1'b0;
  logic tdo, captureDr, shiftDr, updateWr, traceSel, scanSel, dbgEnSel;
  logic [11:0] gpSel;
  int total = 0, bad = 0;

  always #2 tck = ~tck;

  tap_ext_sel i_tap_ext_sel (
    .tck(tck), .tms(tms), .tdi(tdi), .trstN(trstN), .extData(extData),
    .tdo(tdo), .captureDr(captureDr), .shiftDr(shiftDr), .updateWr(updateWr),
    .gpSel(gpSel), .traceSel(traceSel), .scanSel(scanSel), .dbgEnSel(dbgEnSel)
  );

  // select code, expected {dbgEnSel, scanSel, traceSel, gpSel[11:0]}
  localparam logic [21:0] VEC [19] = '{
    {7'h70, 15'h0001}, {7'h71, 15'h0002}, {7'h72, 15'h0004}, {7'h73, 15'h0008},
    {7'h74, 15'h0010}, {7'h75, 15'h0020}, {7'h76, 15'h0040}, {7'h77, 15'h0080},
    {7'h78, 15'h0100}, {7'h79, 15'h0200}, {7'h7A, 15'h0400}, {7'h7B, 15'h0800},
    {7'h7C, 15'h1000}, {7'h7D, 15'h2000}, {7'h7E, 15'h4000}, {7'h7F, 15'h0000},
    {7'h6F, 15'h0000}, {7'h00, 15'h0000}, {7'h3C, 15'h0000}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive inputs, cross one rising and one falling edge, and stop just after the falling edge.
  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  function automatic logic [14:0] sels();
    return {dbgEnSel, scanSel, traceSel, gpSel};
  endfunction

  task automatic loadCmd(input logic [7:0] c, input logic chkIr);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    if (chkIr) chk(tdo == 1'b1, "R8 shift-IR first bit", tdo, 1);
    for (int b = 0; b < 8; b++) step(b == 7, c[b]);
    step(1, 0);
    step(0, 0);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #5;
    chk(sels() == 15'h0 && tdo == 0 && !captureDr && !shiftDr && !updateWr,
        "R9 reset state", {tdo, sels()}, 0);
    @(negedge tck); #1;
    trstN = 1'b1;
    step(0, 0);
    chk(!captureDr && !shiftDr, "R1 R2 idle", {captureDr, shiftDr}, 0);

    for (int v = 0; v < 19; v++) begin
      logic [6:0] code;
      logic [14:0] expS;
      logic ext;
      code = VEC[v][21:15];
      expS = VEC[v][14:0];
      ext = |expS;
      loadCmd({1'b0, code}, v == 0);
      chk(sels() == expS, "R4 R5 R6 decode", sels(), expS);
      step(1, 0);
      extData = 1'b1;
      step(0, 0);
      chk(captureDr && !shiftDr, "R1 capture", {captureDr, shiftDr}, 2'b10);
      step(0, 0);
      chk(shiftDr && !captureDr, "R2 shift", {captureDr, shiftDr}, 2'b01);
      chk(tdo == ext, "R7 R6 first bit", tdo, ext);
      extData = 1'b0;
      step(0, 1);
      chk(tdo == !ext, "R7 R6 second bit", tdo, !ext);
      step(1, 0);
      chk(tdo == 1'b0 && !shiftDr, "R8 tdo low in exit", tdo, 0);
      step(1, 0);
      chk(updateWr == 1'b1, "R3 write update", updateWr, 1);
      step(0, 0);
      chk(updateWr == 1'b0, "R3 update ends", updateWr, 0);
    end

    // read command: no update strobe
    loadCmd(8'hF2, 0);
    chk(sels() == 15'h0004, "R9 read cmd select", sels(), 15'h0004);
    step(1, 0); step(0, 0); step(0, 0); step(1, 0); step(1, 0);
    chk(updateWr == 1'b0, "R3 read suppresses update", updateWr, 0);
    step(0, 0);

    // five TMS high from Shift-DR
    loadCmd(8'h7D, 0);
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 5; k++) step(1, 0);
    chk(!shiftDr && !captureDr && tdo == 0, "R10 tms reset state", {shiftDr, tdo}, 0);
    step(0, 0);
    chk(sels() == 15'h0, "R10 tms reset command", sels(), 0);

    // asynchronous reset
    loadCmd(8'h7E, 0);
    chk(dbgEnSel == 1'b1, "R5 dbgEn before trst", dbgEnSel, 1);
    trstN = 1'b0;
    #1;
    chk(sels() == 15'h0, "R10 trst clears command", sels(), 0);
    #3;
    trstN = 1'b1;
    step(0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule